// File: doc/BRIEF.md
# Cache range maintenance splitter

This block sits in front of a cache maintenance command queue. It takes a single request made of a start address, an end address and an operation (invalidate, clean or flush). It turns that request into a sequence of line-aligned range commands and then issues one sync command. The start address is rounded down to a cache-line boundary. The byte count from that boundary to the end address is rounded up to whole lines, so a partial first line and a partial last line are both covered.

Each range command is limited to a per-command maximum, and that maximum depends on the revision of the controller. If a request covers so much that the rounded length would wrap the address space, the block issues one whole-cache command instead of range commands.

The block sends one command at a time over a valid/ready port. It then waits for a separate completion strobe before it presents the next command. A busy flag covers the whole request, and a one-cycle done pulse marks its end.

Top module: `cache_range_splitter`

## Requirements
- R1: The first range command of a request carries the start address rounded down to a line boundary: `req_start & ~(LINE_BYTES-1)`, with LINE_BYTES a power of two (64 by default).
- R2: The raw length is `req_end` minus the aligned start, taken modulo 2^ADDR_W. It is rounded up to a multiple of LINE_BYTES. The range commands cover exactly that many bytes, in ascending order, with no gaps.
- R3: If the raw length is greater than or equal to 2^ADDR_W − LINE_BYTES, the block issues exactly one command with scope code 1 (whole cache), address 0 and size 0, followed by the sync. A raw length one byte below that threshold is still split as a range.
- R4: Each range command's size is the smaller of the remaining length and the limit. The limit is 4 MiB − LINE_BYTES when `cfg_rev` ≤ 0x16, and 2^ADDR_W − LINE_BYTES otherwise.
- R5: Range commands use scope code 0. Every command of a request, including the whole-cache command and the sync, carries the requested opcode (0 invalidate, 1 clean, 2 flush).
- R6: While `cmd_valid` is high and `cmd_ready` is low, the command fields hold steady. After a handshake, `cmd_valid` stays low until a `cmd_done` strobe arrives.
- R7: Exactly one sync command (scope code 2, address 0, size 0) is issued last in every request. No command follows it.
- R8: When the end address equals the aligned start, no range command is issued and the sync is the only command.
- R9: `req_ready` is high only while the block is idle. `busy` goes high in the cycle after the request is accepted and stays high until the sync's `cmd_done` strobe. `done` pulses for exactly one cycle as `busy` falls.
- R10: After reset, `busy`, `done` and `cmd_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_start | input | ADDR_W | First byte address of the request |
| req_end | input | ADDR_W | End address of the request (exclusive) |
| req_op | input | 2 | Operation: 0 invalidate, 1 clean, 2 flush |
| cfg_rev | input | REV_W | Controller revision; selects the per-command limit |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Queue accepts the command |
| cmd_scope | output | 2 | 0 range, 1 whole cache, 2 sync |
| cmd_op | output | 2 | Operation code of the command |
| cmd_addr | output | ADDR_W | Range start address (0 for whole cache and sync) |
| cmd_size | output | ADDR_W | Range length in bytes (0 for whole cache and sync) |
| cmd_done | input | 1 | One-cycle strobe: the last accepted command has completed |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request finishes |

## Verification
The bench targets the threshold between a range request and the whole-cache fallback from both sides. A wrong comparison would turn the largest legal range into a whole-cache operation, or would let a wrapping length through as a huge range. It also checks that unaligned ends gain one extra line and that an empty request produces only a sync. A design with a wrong rounding mask or a missing zero-length check would miss a line or send a zero-size range. Requests larger than the old-revision limit must split into chunks of limit size with an exact remainder. A design that picked the wrong limit or advanced the address wrongly would show a different command count, size or address. Back-pressure on `cmd_ready` and delayed completion strobes test that a command holds steady and that the next one waits for its strobe.

// File: rtl/csplit_pkg.sv
package csplit_pkg;
  typedef enum logic [1:0] {
    SCOPE_RANGE = 2'd0,
    SCOPE_ALL   = 2'd1,
    SCOPE_SYNC  = 2'd2
  } scope_e;

  localparam logic [1:0] OP_INVALIDATE = 2'd0;
  localparam logic [1:0] OP_CLEAN      = 2'd1;
  localparam logic [1:0] OP_FLUSH      = 2'd2;
endpackage

// File: rtl/csplit_align.sv
// Line alignment of the request and the wrap-around fallback decision.
module csplit_align #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  output logic [ADDR_W-1:0] aligned_start,
  output logic [ADDR_W-1:0] rounded_len,
  output logic              whole_cache
);
  localparam logic [ADDR_W-1:0] LINE_V    = ADDR_W'(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~(LINE_V - 1'b1);
  localparam logic [ADDR_W-1:0] WRAP_TH   = '0 - LINE_V;

  logic [ADDR_W-1:0] raw_len;

  always_comb begin
    aligned_start = start_addr & LINE_MASK;
    raw_len       = end_addr - aligned_start;
    whole_cache   = (raw_len >= WRAP_TH);
    rounded_len   = (raw_len + (LINE_V - 1'b1)) & LINE_MASK;
  end
endmodule

// File: rtl/csplit_limit.sv
// Per-command size limit selected by the controller revision.
module csplit_limit #(
  parameter int ADDR_W          = 32,
  parameter int LINE_BYTES      = 64,
  parameter int REV_W           = 8,
  parameter int OLD_REV_MAX     = 'h16,
  parameter int OLD_LIMIT_BYTES = 1 << 22
) (
  input  logic [REV_W-1:0]  rev,
  output logic [ADDR_W-1:0] limit
);
  localparam logic [ADDR_W-1:0] LINE_V    = ADDR_W'(LINE_BYTES);
  localparam logic [ADDR_W-1:0] OLD_LIMIT = ADDR_W'(OLD_LIMIT_BYTES) - LINE_V;
  localparam logic [ADDR_W-1:0] NEW_LIMIT = '0 - LINE_V;

  always_comb begin
    limit = (rev <= REV_W'(OLD_REV_MAX)) ? OLD_LIMIT : NEW_LIMIT;
  end
endmodule

// File: rtl/cache_range_splitter.sv
module cache_range_splitter
  import csplit_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int LINE_BYTES      = 64,
  parameter int REV_W           = 8,
  parameter int OLD_REV_MAX     = 'h16,
  parameter int OLD_LIMIT_BYTES = 1 << 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic [1:0]        req_op,
  input  logic [REV_W-1:0]  cfg_rev,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_scope,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] cmd_size,
  input  logic              cmd_done,
  output logic              busy,
  output logic              done
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;

  state_e            state_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] limit_q, next_addr_q, remain_q;
  logic              cmd_valid_q, busy_q, done_q;
  scope_e            scope_q;
  logic [ADDR_W-1:0] addr_q, size_q;

  logic [ADDR_W-1:0] al_start, al_len, lim;
  logic              al_whole;
  logic [ADDR_W-1:0] first_chunk, next_chunk;

  csplit_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
    .start_addr   (req_start),
    .end_addr     (req_end),
    .aligned_start(al_start),
    .rounded_len  (al_len),
    .whole_cache  (al_whole)
  );

  csplit_limit #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .REV_W(REV_W),
    .OLD_REV_MAX(OLD_REV_MAX), .OLD_LIMIT_BYTES(OLD_LIMIT_BYTES)
  ) u_limit (
    .rev  (cfg_rev),
    .limit(lim)
  );

  always_comb begin
    first_chunk = (al_len < lim) ? al_len : lim;
    next_chunk  = (remain_q < limit_q) ? remain_q : limit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      op_q        <= '0;
      limit_q     <= '0;
      next_addr_q <= '0;
      remain_q    <= '0;
      cmd_valid_q <= 1'b0;
      scope_q     <= SCOPE_SYNC;
      addr_q      <= '0;
      size_q      <= '0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            op_q        <= req_op;
            limit_q     <= lim;
            busy_q      <= 1'b1;
            cmd_valid_q <= 1'b1;
            state_q     <= ST_ISSUE;
            if (al_whole) begin
              scope_q  <= SCOPE_ALL;
              addr_q   <= '0;
              size_q   <= '0;
              remain_q <= '0;
            end else if (al_len == '0) begin
              scope_q  <= SCOPE_SYNC;
              addr_q   <= '0;
              size_q   <= '0;
              remain_q <= '0;
            end else begin
              scope_q     <= SCOPE_RANGE;
              addr_q      <= al_start;
              size_q      <= first_chunk;
              next_addr_q <= al_start + first_chunk;
              remain_q    <= al_len - first_chunk;
            end
          end
        end
        ST_ISSUE: begin
          if (cmd_ready) begin
            cmd_valid_q <= 1'b0;
            state_q     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cmd_done) begin
            if (scope_q == SCOPE_SYNC) begin
              state_q <= ST_IDLE;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              cmd_valid_q <= 1'b1;
              state_q     <= ST_ISSUE;
              if (scope_q == SCOPE_ALL || remain_q == '0) begin
                scope_q <= SCOPE_SYNC;
                addr_q  <= '0;
                size_q  <= '0;
              end else begin
                scope_q     <= SCOPE_RANGE;
                addr_q      <= next_addr_q;
                size_q      <= next_chunk;
                next_addr_q <= next_addr_q + next_chunk;
                remain_q    <= remain_q - next_chunk;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign cmd_valid = cmd_valid_q;
  assign cmd_scope = scope_q;
  assign cmd_op    = op_q;
  assign cmd_addr  = addr_q;
  assign cmd_size  = size_q;
  assign busy      = busy_q;
  assign done      = done_q;

  AST_RANGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_scope == SCOPE_RANGE) |->
      (cmd_addr[LINE_LSB-1:0] == '0 && cmd_size[LINE_LSB-1:0] == '0 && cmd_size != '0)); // R2

  AST_CHUNK_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_scope == SCOPE_RANGE) |-> (cmd_size <= limit_q)); // R4

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_size) && $stable(cmd_scope) && $stable(cmd_op))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready); // R9

  AST_SYNC_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (cmd_scope == SCOPE_SYNC && !cmd_valid)); // R7
endmodule

// File: tb/cache_range_splitter_tb.sv
`timescale 1ns/1ps
module cache_range_splitter_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_ready;
  logic [AW-1:0] req_start, req_end;
  logic [1:0]    req_op;
  logic [7:0]    cfg_rev;
  logic          cmd_valid, cmd_ready;
  logic [1:0]    cmd_scope, cmd_op;
  logic [AW-1:0] cmd_addr, cmd_size;
  logic          cmd_done, busy, done;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  cache_range_splitter u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_start(req_start), .req_end(req_end), .req_op(req_op), .cfg_rev(cfg_rev),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_scope(cmd_scope), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
    .cmd_done(cmd_done), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected command list: {scope, op, addr, size}
  logic [67:0] exq[$];

  task automatic build(input logic [31:0] s, input logic [31:0] e, input logic [1:0] op, input logic [7:0] rev);
    logic [31:0] al, sz, lim, c;
    exq.delete();
    al  = s & 32'hFFFF_FFC0;
    sz  = e - al;
    lim = (rev <= 8'h16) ? (32'h0040_0000 - 32'd64) : (32'h0 - 32'd64);
    if (sz >= 32'hFFFF_FFC0) begin
      exq.push_back({2'd1, op, 32'd0, 32'd0});
    end else begin
      sz = (sz + 32'd63) & 32'hFFFF_FFC0;
      while (sz != 0) begin
        c = (sz < lim) ? sz : lim;
        exq.push_back({2'd0, op, al, c});
        al = al + c;
        sz = sz - c;
      end
    end
    exq.push_back({2'd2, op, 32'd0, 32'd0});
  endtask

  task automatic run_req(input logic [31:0] s, input logic [31:0] e, input logic [1:0] op,
                         input logic [7:0] rev, input bit stall, input string tag);
    logic [67:0] x;
    int idx;
    build(s, e, op, rev);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_start = s; req_end = e; req_op = op; cfg_rev = rev;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    chk(req_ready == 1'b0, "R9 not ready while busy", req_ready, 0);
    idx = 0;
    while (exq.size() != 0) begin
      x = exq.pop_front();
      while (!cmd_valid) @(negedge clk);
      if (stall) begin
        cmd_ready = 1'b0;
        @(negedge clk);
        chk(cmd_valid == 1'b1, "R6 valid held under stall", cmd_valid, 1);
      end
      chk(cmd_scope == x[67:66], {tag, " scope"}, cmd_scope, x[67:66]);
      chk(cmd_op == x[65:64], "R5 opcode carried", cmd_op, x[65:64]);
      chk(cmd_addr == x[63:32], (idx == 0) ? {tag, " R1 addr"} : {tag, " R2 addr"}, cmd_addr, x[63:32]);
      chk(cmd_size == x[31:0], {tag, " R4 size"}, cmd_size, x[31:0]);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      chk(cmd_valid == 1'b0, "R6 no command before completion", cmd_valid, 0);
      repeat (2) begin
        @(negedge clk);
        chk(cmd_valid == 1'b0 && busy == 1'b1, "R6 waits for completion", {cmd_valid, busy}, 2'b01);
      end
      cmd_done = 1'b1;
      @(negedge clk);
      cmd_done = 1'b0;
      idx++;
    end
    chk(done == 1'b1 && busy == 1'b0, "R9 done pulse with busy low", {done, busy}, 2'b10);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    chk(cmd_valid == 1'b0, "R7 nothing after sync", cmd_valid, 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_start = '0; req_end = '0; req_op = '0;
    cfg_rev = '0; cmd_ready = 1'b0; cmd_done = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, done, cmd_valid, req_ready} == 4'b0001, "R10 reset state",
        {busy, done, cmd_valid, req_ready}, 4'b0001);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, cmd_valid, req_ready} == 4'b0001, "R10 after release",
        {busy, done, cmd_valid, req_ready}, 4'b0001);

    // R1 R2: unaligned start and end, clean
    run_req(32'h0000_1234, 32'h0000_1301, 2'd1, 8'h20, 1'b0, "R1 R2 unaligned");
    // R4: old revision splits 9 MiB into limit-sized chunks, flush
    run_req(32'h0000_0100, 32'h0090_0100, 2'd2, 8'h16, 1'b1, "R4 old rev split");
    // R4: newer revision keeps one chunk
    run_req(32'h0000_0100, 32'h0090_0100, 2'd2, 8'h17, 1'b0, "R4 new rev single");
    // R3: wrap-around length falls back to whole cache, invalidate
    run_req(32'h0000_0040, 32'h0000_0000, 2'd0, 8'h20, 1'b1, "R3 fallback wrap");
    // R8: end equal to aligned start gives only a sync
    run_req(32'h0000_2010, 32'h0000_2000, 2'd1, 8'h10, 1'b0, "R8 empty");
    // R3: one byte below the threshold still a range
    run_req(32'h0000_0000, 32'hFFFF_FFBF, 2'd2, 8'h30, 1'b1, "R3 below threshold");
    // R3: exactly at the threshold
    run_req(32'h0000_0000, 32'hFFFF_FFC0, 2'd0, 8'h30, 1'b0, "R3 at threshold");
    // R5: invalidate over a small aligned range on old revision
    run_req(32'h0001_0000, 32'h0001_0080, 2'd0, 8'h11, 1'b1, "R5 invalidate");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule